// File: doc/BRIEF.md
# Tag-Matching Reservation Station Pool

This block is a small pool of reservation stations that feeds one class of arithmetic operations. An issue port writes an operation into the lowest-numbered free station. Each source operand arrives either as a ready value or as the tag of the station that will produce it. A waiting station watches a broadcast result bus. When a broadcast carries the tag it is waiting for, the station copies the data in that same cycle. Operands can therefore arrive in any order, and they never come from a register read.

Once both operands are present, the station runs a fixed-latency countdown that models its execution unit. It then requests the result bus. A fixed-priority arbiter lets one station per cycle drive its result, which is tagged with that station's identifier. The winning station is freed in that cycle. The arithmetic is an integer stand-in.

The pool drives its own result onto the `res_*` outputs. At chip level, the bus that the pool snoops (`cdb_*`) is the merged broadcast from this pool and from the other producers.

Top module: `rs_pool`

## Requirements
- R1: Reset is asserted asynchronously by `rst_n` low and released through two clock stages. After reset, every station is free: `full` is 0, `res_valid` is 0, and `iss_tag` is the first station tag.
- R2: A cycle with `iss_valid` high and `full` low writes the issue into the lowest-numbered free station. `iss_tag` shows that station's tag, which is `TAG_BASE + index` (1, 2, 3 by default).
- R3: `full` is high exactly when every station is busy. An issue presented while `full` is high is ignored, and no station is overwritten.
- R4: A source tag of 0 means the value is already valid. Op codes are 0 add, 1 subtract, 2 multiply and 3 divide, with latencies of 3, 3, 10 and 40 cycles. A station issued in cycle c with both tags 0 broadcasts in cycle c+L.
- R5: A waiting station whose first or second tag equals the tag of a valid broadcast copies the bus data into that operand and clears the tag. If both operands are then present, execution starts, and the station broadcasts L cycles after the capture cycle.
- R6: An issue whose source tag equals a broadcast in the issue cycle takes the broadcast data rather than keeping the tag.
- R7: At most one result is driven per cycle. Among finished stations, the lowest-numbered one wins, and the others hold their results and retry in later cycles.
- R8: A station is freed at the end of the cycle in which its result is driven. It can accept an issue in the next cycle.
- R9: The results are: add, vj+vk mod 2^64; subtract, vj−vk mod 2^64; multiply, the unsigned 64-bit product of the low 32 bits of each operand; divide stand-in, vj shifted right by vk[5:0].
- R10: A bus cycle with `cdb_valid` low, a tag of 0, or a tag no station waits on changes no operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 2 | Operation code |
| iss_vj | input | 64 | First operand value |
| iss_qj | input | 4 | First operand producer tag, 0 = ready |
| iss_vk | input | 64 | Second operand value |
| iss_qk | input | 4 | Second operand producer tag, 0 = ready |
| iss_tag | output | 4 | Tag the next issue will receive |
| full | output | 1 | All stations busy; issue stalls |
| cdb_valid | input | 1 | Snooped broadcast valid |
| cdb_tag | input | 4 | Snooped broadcast producer tag |
| cdb_data | input | 64 | Snooped broadcast data |
| res_valid | output | 1 | This pool drives a result |
| res_tag | output | 4 | Tag of the producing station |
| res_data | output | 64 | Result value |

## Verification
The bench targets several corner cases, each checked through result tag, data and exact broadcast cycle:
- Three stations finishing in the same cycle. A broken arbiter would drop or duplicate a result, or emit the results in the wrong order or cycle.
- An issue that lands in the same cycle as the broadcast it depends on. A design that keeps the stale tag would never broadcast.
- Broadcasts with the valid bit low, a tag of 0, or a foreign tag. Capturing any of these corrupts the sum or starts execution early.
- An issue attempted while full. Accepting it would overwrite a station and produce a wrong or extra result.
- Dependent chains on both operand sides. These expose capture on the wrong side or a latency counted from the wrong edge.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } rs_op_e;
endpackage

// File: rtl/rs_pick.sv
// Fixed-priority picker: lowest set bit wins.
module rs_pick #(
  parameter int N  = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  in_vec,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    onehot = '0;
    idx    = '0;
    any    = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (in_vec[i]) begin
        onehot = '0;
        onehot[i] = 1'b1;
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_alu.sv
// Integer stand-in for the execution unit, shared after the arbiter.
module rs_alu
  import rs_pkg::*;
#(
  parameter int DW = 64,
  localparam int HW  = DW / 2,
  localparam int SHW = $clog2(DW)
) (
  input  rs_op_e        op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  logic [HW-1:0] a_lo, b_lo;
  assign a_lo = a[HW-1:0];
  assign b_lo = b[HW-1:0];

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = DW'(a_lo) * DW'(b_lo);
      default: y = a >> b[SHW-1:0];
    endcase
  end
endmodule

// File: rtl/rs_entry.sv
// One reservation station: operand capture, countdown, result request.
module rs_entry
  import rs_pkg::*;
#(
  parameter int DW      = 64,
  parameter int TW      = 4,
  parameter int CW      = 6,
  parameter int LAT_ADD = 3,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  rs_op_e        ld_op,
  input  logic [DW-1:0] ld_vj,
  input  logic [TW-1:0] ld_qj,
  input  logic [DW-1:0] ld_vk,
  input  logic [TW-1:0] ld_qk,
  input  logic          bus_v,
  input  logic [TW-1:0] bus_tag,
  input  logic [DW-1:0] bus_data,
  input  logic          grant,
  output logic          busy,
  output logic          req,
  output rs_op_e        op,
  output logic [DW-1:0] vj,
  output logic [DW-1:0] vk
);
  localparam logic [CW-1:0] C_ADD = CW'(LAT_ADD - 1);
  localparam logic [CW-1:0] C_MUL = CW'(LAT_MUL - 1);
  localparam logic [CW-1:0] C_DIV = CW'(LAT_DIV - 1);

  function automatic logic [CW-1:0] start_cnt(rs_op_e o);
    case (o)
      OP_MUL:  return C_MUL;
      OP_DIV:  return C_DIV;
      default: return C_ADD;
    endcase
  endfunction

  logic          busy_q, busy_d;
  logic          exec_q, exec_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] qj_q, qj_d, qk_q, qk_d;
  logic [DW-1:0] vj_q, vj_d, vk_q, vk_d;
  rs_op_e        op_q, op_d;
  logic          snoop_ok, en;

  assign snoop_ok = bus_v && (bus_tag != '0);
  assign en       = load | busy_q;

  always_comb begin
    busy_d = busy_q;
    exec_d = exec_q;
    cnt_d  = cnt_q;
    qj_d   = qj_q;
    qk_d   = qk_q;
    vj_d   = vj_q;
    vk_d   = vk_q;
    op_d   = op_q;
    if (load) begin
      busy_d = 1'b1;
      op_d   = ld_op;
      qj_d   = ld_qj;
      vj_d   = ld_vj;
      qk_d   = ld_qk;
      vk_d   = ld_vk;
      if (snoop_ok && (ld_qj == bus_tag)) begin
        qj_d = '0;
        vj_d = bus_data;
      end
      if (snoop_ok && (ld_qk == bus_tag)) begin
        qk_d = '0;
        vk_d = bus_data;
      end
      exec_d = (qj_d == '0) && (qk_d == '0);
      cnt_d  = start_cnt(ld_op);
    end else if (busy_q) begin
      if (exec_q) begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CW'(1);
        end else if (grant) begin
          busy_d = 1'b0;
          exec_d = 1'b0;
        end
      end else begin
        if (snoop_ok && (qj_q == bus_tag)) begin
          qj_d = '0;
          vj_d = bus_data;
        end
        if (snoop_ok && (qk_q == bus_tag)) begin
          qk_d = '0;
          vk_d = bus_data;
        end
        exec_d = (qj_d == '0) && (qk_d == '0);
        cnt_d  = start_cnt(op_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      exec_q <= 1'b0;
      cnt_q  <= '0;
      qj_q   <= '0;
      qk_q   <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      exec_q <= exec_d;
      cnt_q  <= cnt_d;
      qj_q   <= qj_d;
      qk_q   <= qk_d;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      vj_q <= vj_d;
      vk_q <= vk_d;
      op_q <= op_d;
    end
  end

  assign busy = busy_q;
  assign req  = busy_q && exec_q && (cnt_q == '0);
  assign op   = op_q;
  assign vj   = vj_q;
  assign vk   = vk_q;
endmodule

// File: rtl/rs_pool.sv
// Pool of reservation stations with issue picker and result arbiter.
module rs_pool
  import rs_pkg::*;
#(
  parameter int N        = 3,
  parameter int DW       = 64,
  parameter int TW       = 4,
  parameter int TAG_BASE = 1,
  parameter int LAT_ADD  = 3,
  parameter int LAT_MUL  = 10,
  parameter int LAT_DIV  = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [1:0]    iss_op,
  input  logic [DW-1:0] iss_vj,
  input  logic [TW-1:0] iss_qj,
  input  logic [DW-1:0] iss_vk,
  input  logic [TW-1:0] iss_qk,
  output logic [TW-1:0] iss_tag,
  output logic          full,
  input  logic          cdb_valid,
  input  logic [TW-1:0] cdb_tag,
  input  logic [DW-1:0] cdb_data,
  output logic          res_valid,
  output logic [TW-1:0] res_tag,
  output logic [DW-1:0] res_data
);
  localparam int IW     = (N > 1) ? $clog2(N) : 1;
  localparam int LAT_MX = (LAT_DIV > LAT_MUL) ? ((LAT_DIV > LAT_ADD) ? LAT_DIV : LAT_ADD)
                                              : ((LAT_MUL > LAT_ADD) ? LAT_MUL : LAT_ADD);
  localparam int CW     = $clog2(LAT_MX + 1);
  localparam logic [TW-1:0] TB = TW'(TAG_BASE);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta, rst_core;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_core <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_core <= rst_meta;
    end
  end

  logic [N-1:0]  busy_vec, req_vec, gnt_vec, free_oh, load_vec;
  logic [IW-1:0] free_idx, gnt_idx;
  logic          any_free, any_req;
  rs_op_e        op_arr [N];
  logic [DW-1:0] vj_arr [N];
  logic [DW-1:0] vk_arr [N];
  logic [DW-1:0] alu_y;

  rs_pick #(.N(N)) u_free (
    .in_vec(~busy_vec), .onehot(free_oh), .idx(free_idx), .any(any_free)
  );

  assign full     = ~any_free;
  assign iss_tag  = TB + TW'(free_idx);
  assign load_vec = free_oh & {N{iss_valid}};

  for (genvar g = 0; g < N; g++) begin : g_st
    rs_entry #(
      .DW(DW), .TW(TW), .CW(CW),
      .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
    ) u_st (
      .clk      (clk),
      .rst_n    (rst_core),
      .load     (load_vec[g]),
      .ld_op    (rs_op_e'(iss_op)),
      .ld_vj    (iss_vj),
      .ld_qj    (iss_qj),
      .ld_vk    (iss_vk),
      .ld_qk    (iss_qk),
      .bus_v    (cdb_valid),
      .bus_tag  (cdb_tag),
      .bus_data (cdb_data),
      .grant    (gnt_vec[g]),
      .busy     (busy_vec[g]),
      .req      (req_vec[g]),
      .op       (op_arr[g]),
      .vj       (vj_arr[g]),
      .vk       (vk_arr[g])
    );
  end

  rs_pick #(.N(N)) u_arb (
    .in_vec(req_vec), .onehot(gnt_vec), .idx(gnt_idx), .any(any_req)
  );

  rs_alu #(.DW(DW)) u_alu (
    .op(op_arr[gnt_idx]), .a(vj_arr[gnt_idx]), .b(vk_arr[gnt_idx]), .y(alu_y)
  );

  assign res_valid = any_req;
  assign res_tag   = any_req ? (TB + TW'(gnt_idx)) : '0;
  assign res_data  = any_req ? alu_y : '0;
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int N  = 3,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  busy,
  input logic [N-1:0]  req,
  input logic [N-1:0]  gnt,
  input logic          full,
  input logic          iss_valid,
  input logic          res_valid,
  input logic [TW-1:0] res_tag
);
  a_r7_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r7_loser_retries: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req & ~gnt)) |=> ((req & $past(req & ~gnt)) == $past(req & ~gnt)));

  a_r8_winner_freed: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> ((busy & $past(gnt)) == '0));

  a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (full && iss_valid) |=> ($countones(busy) <= $past($countones(busy))));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy == '0) |-> !res_valid);

  a_r2_tag_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_tag != '0));
endmodule

bind rs_pool rs_pool_chk #(.N(N), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_vec), .req(req_vec), .gnt(gnt_vec),
  .full(full), .iss_valid(iss_valid), .res_valid(res_valid), .res_tag(res_tag)
);

// File: tb/sim_rs_pool.sv
module sim_rs_pool;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [1:0]  iss_op = '0;
  logic [63:0] iss_vj = '0, iss_vk = '0;
  logic [3:0]  iss_qj = '0, iss_qk = '0;
  logic [3:0]  iss_tag;
  logic        full;
  logic        inj_v = 1'b0;
  logic [3:0]  inj_tag = '0;
  logic [63:0] inj_data = '0;
  logic        cdb_valid;
  logic [3:0]  cdb_tag;
  logic [63:0] cdb_data;
  logic        res_valid;
  logic [3:0]  res_tag;
  logic [63:0] res_data;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic [3:0]  tag;
    logic [63:0] data;
    int          cyc;
    string       rq;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign cdb_valid = res_valid | inj_v;
  assign cdb_tag   = res_valid ? res_tag : inj_tag;
  assign cdb_data  = res_valid ? res_data : inj_data;

  rs_pool u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_vj(iss_vj), .iss_qj(iss_qj), .iss_vk(iss_vk), .iss_qk(iss_qk),
    .iss_tag(iss_tag), .full(full), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .cdb_data(cdb_data), .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data)
  );

  task automatic check(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", rq, what, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: issue one op in the current cycle, push the expected result.
  task automatic issue(input logic [1:0] op, input logic [63:0] a, input logic [3:0] qa,
                       input logic [63:0] b, input logic [3:0] qb,
                       input logic [3:0] etag, input logic [63:0] edata,
                       input int dly, input string rq);
    exp_t e;
    check("R2", "issue tag", 64'(iss_tag), 64'(etag));
    check("R3", "full before issue", 64'(full), 64'd0);
    e.tag = etag; e.data = edata; e.cyc = cyc + dly; e.rq = rq;
    sb.push_back(e);
    iss_valid = 1'b1; iss_op = op; iss_vj = a; iss_qj = qa; iss_vk = b; iss_qk = qb;
    @(negedge clk);
    iss_valid = 1'b0; iss_qj = '0; iss_qk = '0;
  endtask

  task automatic issue_blocked(input logic [63:0] a);
    check("R3", "full during blocked issue", 64'(full), 64'd1);
    iss_valid = 1'b1; iss_op = 2'd0; iss_vj = a; iss_qj = '0; iss_vk = a; iss_qk = '0;
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic inject(input logic v, input logic [3:0] t, input logic [63:0] d);
    inj_v = v; inj_tag = t; inj_data = d;
    @(negedge clk);
    inj_v = 1'b0; inj_tag = '0; inj_data = '0;
  endtask

  task automatic drain();
    int n = 0;
    while (sb.size() != 0 && n < 300) begin
      @(negedge clk);
      n++;
    end
    if (sb.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL %s missing result: actual=none expected tag %0d data %h",
               sb[0].rq, sb[0].tag, sb[0].data);
      sb.delete();
    end
    tick(2);
  endtask

  // Monitor: pop the expected item with the same tag and compare.
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      int k = -1;
      for (int i = 0; i < sb.size(); i++)
        if (k < 0 && sb[i].tag == res_tag) k = i;
      if (k < 0) begin
        checks++;
        errors++;
        $display("FAIL R3 unexpected result: actual tag %0d data %h expected none", res_tag, res_data);
      end else begin
        check(sb[k].rq, "result data", res_data, sb[k].data);
        check(sb[k].rq, "result cycle", 64'(cyc), 64'(sb[k].cyc));
        sb.delete(k);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    check("R1", "full after reset", 64'(full), 64'd0);
    check("R1", "res_valid after reset", 64'(res_valid), 64'd0);
    check("R1", "first tag", 64'(iss_tag), 64'd1);

    // R4/R9 simple add
    issue(2'd0, 64'd5, 4'd0, 64'd7, 4'd0, 4'd1, 64'd12, 3, "R4");
    drain();

    // R9 sub wrap, mul low halves, div stand-in; R3 full, R8 free
    issue(2'd1, 64'd3, 4'd0, 64'd5, 4'd0, 4'd1, 64'hFFFF_FFFF_FFFF_FFFE, 3, "R9");
    issue(2'd2, 64'h1_0000_0003, 4'd0, 64'h5_0000_0005, 4'd0, 4'd2, 64'd15, 10, "R9");
    issue(2'd3, 64'd256, 4'd0, 64'hFFFF_FFFF_FFFF_FF04, 4'd0, 4'd3, 64'd16, 40, "R4");
    check("R3", "full with all busy", 64'(full), 64'd1);
    tick(1);
    check("R8", "full after free", 64'(full), 64'd0);
    check("R8", "freed tag reused", 64'(iss_tag), 64'd1);
    drain();

    // R5 dependency chain on both operand sides
    issue(2'd2, 64'd6, 4'd0, 64'd7, 4'd0, 4'd1, 64'd42, 10, "R4");
    issue(2'd0, 64'd0, 4'd1, 64'd8, 4'd0, 4'd2, 64'd50, 12, "R5");
    issue(2'd1, 64'd100, 4'd0, 64'd0, 4'd2, 4'd3, 64'd50, 14, "R5");
    drain();

    // R6 issue in the same cycle as the producing broadcast
    issue(2'd0, 64'd1, 4'd0, 64'd2, 4'd0, 4'd1, 64'd3, 3, "R4");
    tick(2);
    issue(2'd0, 64'd10, 4'd0, 64'd0, 4'd1, 4'd2, 64'd13, 3, "R6");
    drain();

    // R10 ignored bus cycles, then R5 external captures
    issue(2'd0, 64'd0, 4'd9, 64'd0, 4'd10, 4'd1, 64'd123, 9, "R10");
    tick(1);
    inject(1'b1, 4'd0, 64'd77);
    inject(1'b0, 4'd9, 64'd55);
    inject(1'b1, 4'd9, 64'd100);
    inject(1'b1, 4'd11, 64'd999);
    inject(1'b1, 4'd10, 64'd23);
    drain();

    // R7 three stations finish together; R3 blocked issue while full
    issue(2'd0, 64'd0, 4'd9, 64'd1, 4'd0, 4'd1, 64'd1001, 7, "R7");
    issue(2'd0, 64'd0, 4'd9, 64'd2, 4'd0, 4'd2, 64'd1002, 7, "R7");
    issue(2'd0, 64'd0, 4'd9, 64'd3, 4'd0, 4'd3, 64'd1003, 7, "R7");
    issue_blocked(64'd1);
    inject(1'b1, 4'd9, 64'd1000);
    drain();

    // R9 wide multiply and full-range shift
    issue(2'd2, 64'hFFFF_FFFF, 4'd0, 64'hFFFF_FFFF, 4'd0, 4'd1, 64'hFFFF_FFFE_0000_0001, 10, "R9");
    issue(2'd3, 64'h8000_0000_0000_0000, 4'd0, 64'd63, 4'd0, 4'd2, 64'd1, 40, "R9");
    drain();
    check("R8", "pool empty at end", 64'(full), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule